// File: doc/BRIEF.md
# Fall-Through FIFO Built from a Chain of Storage Cells

This block is a first-in, first-out queue made of a linear row of identical storage cells instead of a RAM addressed by read and write pointers. Cell 0 sits at the input end and cell `DEPTH-1` is the output cell. A word that is accepted falls down the row within the same cycle and is stored in the deepest cell that will be empty after that cycle's dequeue, if any. Each cell asks its successor whether it will be empty. A cell hands its word onward when the successor can take it. When the output cell is read, every occupied cell pulls the word of its predecessor, so the occupied cells always form one unbroken run that ends at the output cell.

The input end can carry an optional side slot (`USE_DEFER`). The slot holds back one enqueue that arrives while cell 0 is busy and releases it into the row as soon as room appears. With the slot the queue holds `DEPTH+1` words. Without it the queue holds `DEPTH` words. The data type plays no part in cell behaviour: only the width parameter changes. Each cell drives one bit of the exported occupancy vector.

Top module: `ftf_fifo`

## Requirements
- R1: After reset every bit of `cell_full` is 0, `out_valid` is 0, and `in_ready` is 1.
- R2: A word accepted into an empty queue is on `out_data`, with `out_valid` at 1, directly after the clock edge that accepted it.
- R3: An accepted word is stored in the deepest cell left empty after that cycle. Bit `DEPTH-1` of `cell_full` is the output cell, so with n words in the row the top n bits are 1 and all other bits are 0.
- R4: A cycle with `out_valid` and `out_ready` both high removes the output word. Each remaining word moves one cell toward the output at that same edge.
- R5: Words leave in exactly the order in which they were accepted.
- R6: When `DEPTH+1` words are held and `out_ready` is low, `in_ready` is 0. A word offered in that cycle leaves the contents and the occupancy unchanged.
- R7: When all `DEPTH` cells are full and the side slot is empty, `in_ready` stays 1 and the word is held in the side slot. `cell_full` is unchanged. The held word enters the row in the first cycle that frees cell 0, ahead of any later word.
- R8: On a queue holding `DEPTH+1` words, an enqueue offered together with a dequeue sees `in_ready` at 1 and is accepted, and occupancy stays the same.
- R9: A dequeue request on an empty queue has no effect: `out_valid` stays 0, and the next enqueue behaves as it would from reset.
- R10: On a partly filled queue, a simultaneous enqueue and dequeue keeps `cell_full` unchanged. The new word lands in the highest-index cell that the shift left free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Enqueue request |
| in_data | input | DATA_W | Word to enqueue |
| in_ready | output | 1 | Enqueue is accepted this cycle when high |
| out_valid | output | 1 | The output cell holds a word |
| out_data | output | DATA_W | Word in the output cell; meaningless while `out_valid` is low |
| out_ready | input | 1 | Dequeue request, acted on only when `out_valid` is high |
| cell_full | output | DEPTH | Occupancy flag for each cell; bit `DEPTH-1` is the output cell |

## Verification
The hardest state to reach is the one where the row is full, the side slot holds a word, and an enqueue and a dequeue arrive in the same cycle. In that cycle three movements must happen at one edge: the slot empties into cell 0, the new word refills the slot, and the output cell shifts. The stimulus gets there by filling the row one word at a time, offering one more word that parks in the slot, offering a further word that must be refused, and only then raising both requests together. The following drain then shows whether the slot word and the new word kept their order.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

   // Number of words the queue can hold for a given row length and slot option.
   function automatic int unsigned ftf_capacity(input int unsigned depth,
                                                input int unsigned use_defer);
      return depth + ((use_defer != 0) ? 1 : 0);
   endfunction

endpackage

// File: rtl/ftf_cell.sv
module ftf_cell #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_full_i,
   input  logic              pred_move_i,
   input  logic [DATA_W-1:0] pred_data_i,
   input  logic              succ_accept_i,
   input  logic              succ_free_i,
   input  logic              arrive_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic              full_o,
   output logic [DATA_W-1:0] data_o,
   output logic              accept_o,
   output logic              move_o,
   output logic              free_o,
   output logic              pass_o
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;
   logic              keep;
   logic              land;

   // The word leaves when the successor can take it (empty, pulling, or a dequeue).
   assign keep     = full_q & ~succ_accept_i;
   assign move_o   = full_q & succ_accept_i;
   assign accept_o = ~full_q | succ_accept_i;
   // Empty after this cycle: nothing stays here and nothing is pulled in.
   assign free_o   = ~keep & ~pred_move_i;
   // A falling word goes on while the next cell will be empty, otherwise it stops here.
   assign pass_o   = arrive_i & succ_free_i;
   assign land     = arrive_i & ~succ_free_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         full_q <= keep | pred_move_i | land;
         if (land)
            data_q <= push_data_i;
         else if (pred_move_i)
            data_q <= pred_data_i;
      end
   end

   assign full_o = full_q;
   assign data_o = data_q;

   // Occupied cells form one run ending at the output: a full predecessor implies a full cell.
   assert_no_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pred_full_i |-> full_q);

   // A word that is not taken stays put with its value.
   assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !succ_accept_i) |=> (full_q && $stable(data_q)));

   // A word is never dropped into a cell that is receiving its predecessor's word.
   assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arrive_i |-> !pred_move_i);

endmodule

// File: rtl/ftf_defer_slot.sv
module ftf_defer_slot #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              chain_free_i,
   output logic              in_ready_o,
   output logic              push_o,
   output logic [DATA_W-1:0] push_data_o
);

   logic              slot_full;
   logic [DATA_W-1:0] slot_q;

   // The held word is older, so it always goes to the row before a new one.
   assign push_o      = (slot_full | in_valid_i) & chain_free_i;
   assign push_data_o = slot_full ? slot_q : in_data_i;
   assign in_ready_o  = ~slot_full | chain_free_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_full <= 1'b0;
         slot_q    <= '0;
      end else if (slot_full) begin
         if (chain_free_i) begin
            slot_full <= in_valid_i;
            slot_q    <= in_data_i;
         end
      end else if (in_valid_i && !chain_free_i) begin
         slot_full <= 1'b1;
         slot_q    <= in_data_i;
      end
   end

   // A held word waits unchanged while the row has no room.
   assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_full && !chain_free_i) |=> (slot_full && $stable(slot_q)));

   // An accepted word that cannot enter the row is parked.
   assert_slot_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o && !chain_free_i) |=> slot_full);

endmodule

// File: rtl/ftf_fifo.sv
module ftf_fifo
   import ftf_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned USE_DEFER = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   output logic [DEPTH-1:0]  cell_full
);

   localparam int unsigned CAPACITY = ftf_capacity(DEPTH, USE_DEFER);
   localparam int unsigned LAST     = DEPTH - 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("ftf_fifo: DEPTH must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ftf_fifo: DATA_W must be at least 1");
   end
   if (USE_DEFER > 1) begin : g_bad_defer
      $error("ftf_fifo: USE_DEFER must be 0 or 1");
   end
   if (CAPACITY < DEPTH) begin : g_bad_cap
      $error("ftf_fifo: capacity below row length");
   end

   // Boundary signals: index i is the input side of cell i, index DEPTH is past the output.
   logic [DEPTH-1:0]  full_w;
   logic [DEPTH-1:0]  move_w;
   logic [DEPTH:0]    accept_w;
   logic [DEPTH:0]    free_w;
   logic [DEPTH:0]    arrive_w;
   logic [DATA_W-1:0] data_w [DEPTH];
   logic [DATA_W-1:0] push_data;
   logic              push;

   assign accept_w[DEPTH] = out_ready;
   assign free_w[DEPTH]   = 1'b0;
   assign arrive_w[0]     = push;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic              pred_full;
      logic              pred_move;
      logic [DATA_W-1:0] pred_data;

      if (i == 0) begin : g_head
         assign pred_full = 1'b0;
         assign pred_move = 1'b0;
         assign pred_data = '0;
      end else begin : g_body
         assign pred_full = full_w[i-1];
         assign pred_move = move_w[i-1];
         assign pred_data = data_w[i-1];
      end

      ftf_cell #(.DATA_W(DATA_W)) cell_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .pred_full_i  (pred_full),
         .pred_move_i  (pred_move),
         .pred_data_i  (pred_data),
         .succ_accept_i(accept_w[i+1]),
         .succ_free_i  (free_w[i+1]),
         .arrive_i     (arrive_w[i]),
         .push_data_i  (push_data),
         .full_o       (full_w[i]),
         .data_o       (data_w[i]),
         .accept_o     (accept_w[i]),
         .move_o       (move_w[i]),
         .free_o       (free_w[i]),
         .pass_o       (arrive_w[i+1])
      );
   end

   if (USE_DEFER != 0) begin : g_defer
      ftf_defer_slot #(.DATA_W(DATA_W)) slot_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .in_valid_i  (in_valid),
         .in_data_i   (in_data),
         .chain_free_i(free_w[0]),
         .in_ready_o  (in_ready),
         .push_o      (push),
         .push_data_o (push_data)
      );
   end else begin : g_direct
      assign in_ready  = free_w[0];
      assign push      = in_valid & free_w[0];
      assign push_data = in_data;
   end

   assign out_valid = full_w[LAST];
   assign out_data  = data_w[LAST];
   assign cell_full = full_w;

   // A falling word always finds a cell to stop in.
   assert_no_spill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !arrive_w[DEPTH]);

   // Only a handshake at the output moves the output word.
   assert_deq_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      move_w[LAST] |-> (out_valid && out_ready));

   // A refused word leaves the row full.
   assert_refuse_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> (&cell_full));

   // Row that takes nothing from the input side is entirely occupied.
   assert_head_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_w[0] |-> (&full_w));

   // Simultaneous enqueue and dequeue on a full row keeps it full.
   assert_swap_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cell_full) && out_ready && in_valid && in_ready) |=> (&cell_full));

   // Dequeue on an empty queue with no enqueue leaves it empty.
   assert_empty_deq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: tb/ftf_fifo_tb_top.sv
module ftf_fifo_tb_top;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned CAP    = DEPTH + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_ready;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;
   logic              out_ready = 1'b0;
   logic [DEPTH-1:0]  cell_full;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          done = 1'b0;
   logic [DATA_W-1:0] model_q[$];

   always #10 clk = ~clk;

   ftf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .USE_DEFER(1)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_ready(out_ready),
      .cell_full(cell_full)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DEPTH-1:0] thermo(input int unsigned n);
      logic [DEPTH-1:0] v = '0;
      for (int k = 0; k < DEPTH; k++)
         if (k >= int'(DEPTH) - int'(n)) v[k] = 1'b1;
      return v;
   endfunction

   // Compare the visible state against the reference queue.
   task automatic chk_state(input string req);
      int unsigned n = model_q.size();
      int unsigned in_row = (n > DEPTH) ? DEPTH : n;
      chk(req, "cell_full", 32'(cell_full), 32'(thermo(in_row)));
      chk(req, "out_valid", 32'(out_valid), 32'(n > 0));
      if (n > 0) chk(req, "out_data", 32'(out_data), 32'(model_q[0]));
   endtask

   // One cycle: drive after the falling edge, check ready, clock, check result.
   task automatic step(input logic v, input logic [DATA_W-1:0] d,
                       input logic r, input string req);
      int unsigned n = model_q.size();
      logic exp_rdy = (n < CAP) || (r && n > 0);
      logic acc;
      logic deq;
      in_valid  = v;
      in_data   = d;
      out_ready = r;
      #2;
      chk(req, "in_ready", 32'(in_ready), 32'(exp_rdy));
      acc = v && exp_rdy;
      deq = r && (n > 0);
      @(posedge clk);
      if (deq) void'(model_q.pop_front());
      if (acc) model_q.push_back(d);
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      chk_state(req);
   endtask

   task automatic drain(input string req);
      while (model_q.size() > 0) step(1'b0, '0, 1'b1, req);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      model_q.delete();
      chk("R1", "cell_full", 32'(cell_full), 32'(0));
      chk("R1", "out_valid", 32'(out_valid), 32'(0));
      chk("R1", "in_ready", 32'(in_ready), 32'(1));
   endtask

   task automatic t_single;
      step(1'b1, 8'hA0, 1'b0, "R2");
      chk("R2", "out_data", 32'(out_data), 32'h0A0);
      step(1'b0, '0, 1'b1, "R4");
      chk("R4", "out_valid", 32'(out_valid), 32'(0));
   endtask

   task automatic t_fill_defer_refuse_swap;
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'(8'h10 + k), 1'b0, "R3");
      step(1'b1, 8'h20, 1'b0, "R7");
      chk("R7", "cell_full", 32'(cell_full), 32'({DEPTH{1'b1}}));
      step(1'b1, 8'hEE, 1'b0, "R6");
      step(1'b1, 8'hEF, 1'b0, "R6");
      step(1'b1, 8'h55, 1'b1, "R8");
      chk("R8", "cell_full", 32'(cell_full), 32'({DEPTH{1'b1}}));
      drain("R5");
   endtask

   task automatic t_defer_release;
      for (int k = 0; k < CAP; k++) step(1'b1, 8'(8'h30 + k), 1'b0, "R7");
      step(1'b0, '0, 1'b1, "R7");
      step(1'b1, 8'h3F, 1'b0, "R7");
      drain("R7");
   endtask

   task automatic t_empty_deq;
      step(1'b0, '0, 1'b1, "R9");
      step(1'b0, '0, 1'b1, "R9");
      step(1'b1, 8'h77, 1'b0, "R9");
      drain("R9");
   endtask

   task automatic t_mid_swap;
      step(1'b1, 8'h41, 1'b0, "R10");
      step(1'b1, 8'h42, 1'b0, "R10");
      step(1'b1, 8'h43, 1'b1, "R10");
      chk("R10", "cell_full", 32'(cell_full), 32'(thermo(2)));
      step(1'b0, '0, 1'b1, "R10");
      chk("R10", "out_data", 32'(out_data), 32'h043);
      drain("R4");
   endtask

   task automatic t_stream;
      for (int k = 0; k < 24; k++)
         step(1'b1, 8'(8'h80 + k), (k % 3) != 0, "R5");
      drain("R5");
   endtask

   initial begin
      t_reset();
      t_single();
      t_fill_defer_refuse_swap();
      t_defer_release();
      t_empty_deq();
      t_mid_swap();
      t_stream();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule